// File: doc/BRIEF.md
# Biphase-mark subframe decoder

This block takes an oversampled S/PDIF line at a known symbol rate and turns it into one 32-bit word per subframe. A sample strobe marks the ticks at which the line is looked at. Each level run between two transitions is timed in strobe ticks and rounded to one, two or three unit intervals (UI, half a bit cell). A run of three UI cannot occur in valid biphase-mark data, so it marks the start of a preamble. The decoder then classifies the preamble as M, W or B and decodes the 28 data bits that follow. Because only run lengths are used, the block accepts either line polarity without any setting.

Word boundaries come from the preamble itself and not from a free-running bit counter. A finished subframe is handed out as soon as the next preamble is detected. The word carries a one-hot preamble code, the 28 received bits and a parity-check bit computed locally, which is 0 for a good subframe. A frame index travels with the word. It is cleared by B and advanced by M.

A missing preamble or an over-long level run sends the decoder back to hunting and raises a one-cycle sync-lost pulse. A word that finds the output slot still occupied is dropped and flagged. Decoding carries on, so the block never loses its place in the bitstream.

Top module: `bmc_subframe_rx`

## Requirements
- R1: After reset, valid_o, locked_o, sync_lost_o and overflow_o are low and the frame index is 0.
- R2: The length of each level run is counted in sample_en_i ticks from the last transition. A count in [k*OSR-OSR/2, k*OSR+OSR/2-1] is taken as k UI, for k = 1, 2 or 3, so timing error does not add up from one run to the next.
- R3: A 3-UI run seen while hunting or while in data starts a preamble. The second run picks the type: 3 UI gives M, 2 UI gives W, 1 UI gives B. The preamble runs must add up to exactly 8 UI. Both line polarities decode the same way.
- R4: In data, a 2-UI run is a 0 bit and two 1-UI runs in a row are a 1 bit. The first received bit lands in data_o[1] and the 28th (P) in data_o[28].
- R5: A subframe's word is loaded into the output when the next preamble is detected, and only if all 28 bits were received. The preamble code is one-hot: data_o[31]=M, data_o[30]=W, data_o[29]=B.
- R6: data_o[0] is the XOR of the 28 decoded bits. It is 0 when the count of ones is even and 1 after a single bit error.
- R7: frame_o is the index of the word's subframe. A B preamble sets the index to 0, an M preamble increments it, and a W preamble leaves it unchanged.
- R8: Two events drop the decoder to hunting, pull locked_o low, pulse sync_lost_o for one cycle and discard the partial subframe: a level run reaching 3*OSR+OSR/2 ticks, or more than 64 UI passing since the last preamble detection.
- R9: While valid_o is high and ready_i is low, valid_o stays high and data_o and frame_o hold their values.
- R10: A word loaded while valid_o is high and ready_i is low is dropped. overflow_o then pulses for one cycle, the held word is kept, and decoding continues.
- R11: locked_o rises at the first preamble detection and stays high until sync is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Oversampling strobe, OSR ticks per UI |
| line_i | input | 1 | Biphase-mark serial line, synchronous to clk_i |
| data_o | output | 32 | Subframe word: preamble code, 28 bits, parity check |
| frame_o | output | 8 | Frame index within the block for data_o |
| valid_o | output | 1 | Word available |
| ready_i | input | 1 | Consumer accepts word |
| locked_o | output | 1 | Decoder is synchronised |
| sync_lost_o | output | 1 | One-cycle pulse on loss of sync |
| overflow_o | output | 1 | One-cycle pulse when a word is dropped |

## Verification
The hardest states to reach from the ports are the two loss paths that fire inside a subframe, and the drop of a word while an older one is held. The bench builds the line directly from level runs with a controlled tick jitter. This lets it send a subframe with two extra bits, so the 64-UI limit is crossed, and cut a subframe short with a five-UI hold. It also holds ready_i low across a whole burst and expects the first word to survive while three later words are dropped.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;
  localparam int SUB_BITS   = 28;
  localparam int SUB_UI     = 64;
  localparam int PRE_UI     = 8;
  localparam int WORD_W     = 32;
  localparam int BLK_FRAMES = 192;
  localparam int FRM_W      = $clog2(BLK_FRAMES);
  localparam int NB_W       = $clog2(SUB_BITS + 1);
  localparam int UI_W       = $clog2(SUB_UI + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_PRE, ST_DATA} dec_st_e;

  localparam logic [2:0] KIND_M = 3'b100;
  localparam logic [2:0] KIND_W = 3'b010;
  localparam logic [2:0] KIND_B = 3'b001;
endpackage

// File: rtl/bmc_run_meter.sv
module bmc_run_meter #(
  parameter int OSR = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       samp_en_i,
  input  logic       line_i,
  output logic       run_v_o,
  output logic [1:0] run_k_o,
  output logic       run_bad_o
);
  localparam int CW = $clog2(4 * OSR) + 1;
  localparam logic [CW-1:0] T1 = CW'(OSR / 2);
  localparam logic [CW-1:0] T2 = CW'(OSR + OSR / 2);
  localparam logic [CW-1:0] T3 = CW'(2 * OSR + OSR / 2);
  localparam logic [CW-1:0] T4 = CW'(3 * OSR + OSR / 2);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          edge_w, long_w;

  assign edge_w = samp_en_i && (line_i != prev_q);
  assign long_w = samp_en_i && !edge_w && (cnt_q == T4 - 1'b1);

  // round the finished run to whole UIs; 0 means out of range
  always_comb begin
    run_k_o = 2'd0;
    if (cnt_q < T1)      run_k_o = 2'd0;
    else if (cnt_q < T2) run_k_o = 2'd1;
    else if (cnt_q < T3) run_k_o = 2'd2;
    else if (cnt_q < T4) run_k_o = 2'd3;
  end

  assign run_v_o   = edge_w || long_w;
  assign run_bad_o = long_w || (edge_w && run_k_o == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '1;
    end else if (samp_en_i) begin
      prev_q <= line_i;
      if (edge_w)             cnt_q <= CW'(1);
      else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  long_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_w |=> !long_w);
endmodule

// File: rtl/bmc_frame_decoder.sv
module bmc_frame_decoder
  import bmc_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_v_i,
  input  logic [1:0]        run_k_i,
  input  logic              run_bad_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic [FRM_W-1:0]  frame_o,
  output logic              locked_o,
  output logic              lost_o
);
  dec_st_e              st_q;
  logic [UI_W-1:0]      ui_q;
  logic [3:0]           pre_q;
  logic                 second_q;
  logic [2:0]           kind_q;
  logic                 half_q;
  logic [NB_W-1:0]      nbit_q;
  logic [SUB_BITS-1:0]  sh_q;
  logic                 par_q;
  logic [FRM_W-1:0]     frm_q;
  logic                 push_q, lost_q;
  logic [WORD_W-1:0]    word_q;
  logic [FRM_W-1:0]     fout_q;

  logic [UI_W:0] ui_sum;
  logic [4:0]    pre_sum;
  assign ui_sum  = {1'b0, ui_q} + (UI_W+1)'(run_k_i);
  assign pre_sum = {1'b0, pre_q} + 5'(run_k_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT;  ui_q <= '0;  pre_q <= '0;  second_q <= 1'b0;
      kind_q <= KIND_M; half_q <= 1'b0; nbit_q <= '0; sh_q <= '0;
      par_q <= 1'b0;  frm_q <= '0;  push_q <= 1'b0;  lost_q <= 1'b0;
      word_q <= '0;  fout_q <= '0;
    end else begin
      push_q <= 1'b0;
      lost_q <= 1'b0;
      if (run_v_i) begin
        if (run_bad_i) begin
          if (st_q != ST_HUNT) lost_q <= 1'b1;
          st_q <= ST_HUNT;
        end else if (run_k_i == 2'd3 && st_q != ST_PRE) begin
          // code violation: preamble start, flush the finished subframe
          if (st_q == ST_DATA && nbit_q == NB_W'(SUB_BITS) && !half_q) begin
            push_q <= 1'b1;
            word_q <= {kind_q, sh_q, par_q};
            fout_q <= frm_q;
          end
          st_q     <= ST_PRE;
          pre_q    <= 4'd3;
          ui_q     <= UI_W'(3);
          second_q <= 1'b1;
        end else if (st_q == ST_PRE) begin
          if (pre_sum > 5'(PRE_UI)) begin
            st_q   <= ST_HUNT;
            lost_q <= 1'b1;
          end else begin
            pre_q <= pre_sum[3:0];
            ui_q  <= ui_sum[UI_W-1:0];
            if (second_q) begin
              second_q <= 1'b0;
              case (run_k_i)
                2'd3:    kind_q <= KIND_M;
                2'd2:    kind_q <= KIND_W;
                default: kind_q <= KIND_B;
              endcase
            end
            if (pre_sum == 5'(PRE_UI)) begin
              st_q   <= ST_DATA;
              nbit_q <= '0;
              half_q <= 1'b0;
              par_q  <= 1'b0;
              if (kind_q == KIND_B)      frm_q <= '0;
              else if (kind_q == KIND_M) frm_q <= (frm_q == FRM_W'(BLK_FRAMES - 1)) ? '0 : frm_q + 1'b1;
            end
          end
        end else if (st_q == ST_DATA) begin
          if (ui_sum > (UI_W+1)'(SUB_UI) || (run_k_i == 2'd2 && half_q)) begin
            st_q   <= ST_HUNT;
            lost_q <= 1'b1;
          end else begin
            ui_q <= ui_sum[UI_W-1:0];
            if (run_k_i == 2'd2) begin
              sh_q   <= {1'b0, sh_q[SUB_BITS-1:1]};
              nbit_q <= nbit_q + 1'b1;
            end else if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              half_q <= 1'b0;
              sh_q   <= {1'b1, sh_q[SUB_BITS-1:1]};
              par_q  <= ~par_q;
              nbit_q <= nbit_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign push_o   = push_q;
  assign word_o   = word_q;
  assign frame_o  = fout_q;
  assign locked_o = (st_q != ST_HUNT);
  assign lost_o   = lost_q;

  // R8
  ui_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DATA |-> ui_q <= UI_W'(SUB_UI));
  // R5
  push_at_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |-> st_q == ST_PRE && pre_q == 4'd3);
  // R8
  lost_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> st_q == ST_HUNT);
endmodule

// File: rtl/bmc_subframe_rx.sv
module bmc_subframe_rx
  import bmc_rx_pkg::*;
#(
  parameter int OSR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_en_i,
  input  logic              line_i,
  output logic [WORD_W-1:0] data_o,
  output logic [FRM_W-1:0]  frame_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              locked_o,
  output logic              sync_lost_o,
  output logic              overflow_o
);
  logic              run_v, run_bad;
  logic [1:0]        run_k;
  logic              push;
  logic [WORD_W-1:0] word;
  logic [FRM_W-1:0]  frm;

  bmc_run_meter #(.OSR(OSR)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .samp_en_i (sample_en_i),
    .line_i    (line_i),
    .run_v_o   (run_v),
    .run_k_o   (run_k),
    .run_bad_o (run_bad)
  );

  bmc_frame_decoder u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_v_i   (run_v),
    .run_k_i   (run_k),
    .run_bad_i (run_bad),
    .push_o    (push),
    .word_o    (word),
    .frame_o   (frm),
    .locked_o  (locked_o),
    .lost_o    (sync_lost_o)
  );

  logic              out_v_q, ovf_q;
  logic [WORD_W-1:0] out_d_q;
  logic [FRM_W-1:0]  out_f_q;

  // single slot; a word that finds it occupied is discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
      out_f_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (push) begin
        if (out_v_q && !ready_i) begin
          ovf_q <= 1'b1;
        end else begin
          out_v_q <= 1'b1;
          out_d_q <= word;
          out_f_q <= frm;
        end
      end else if (ready_i) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign valid_o    = out_v_q;
  assign data_o     = out_d_q;
  assign frame_o    = out_f_q;
  assign overflow_o = ovf_q;

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(frame_o));
  // R5
  pre_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(data_o[31:29]) == 1);
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> valid_o && $past(valid_o && !ready_i));
  // R11
  lost_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_o |-> !locked_o);
endmodule

// File: tb/tb_bmc_subframe_rx.sv
module tb_bmc_subframe_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OSR = 4;
  localparam logic [2:0] K_M = 3'b100, K_W = 3'b010, K_B = 3'b001;

  logic clk = 1'b0, rst_n, en, line, ready;
  logic [31:0] data;
  logic [7:0]  frame;
  logic valid, locked, lost, ovf;

  bmc_subframe_rx #(.OSR(OSR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(en), .line_i(line),
    .data_o(data), .frame_o(frame), .valid_o(valid), .ready_i(ready),
    .locked_o(locked), .sync_lost_o(lost), .overflow_o(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int lost_cnt = 0, lost_exp = 0, ovf_cnt = 0, ovf_exp = 0;
  int jit_on = 0, jit_idx = 0, frm_m = 0;
  logic lvl = 1'b0;
  string scen = "";
  logic [39:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference side: every clock, compare handshakes with the expected stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (lost) lost_cnt++;
      if (ovf)  ovf_cnt++;
      if (valid && ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected word", {24'd0, frame, data}, 64'd0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({frame, data} == e, "R4 R5 R6 R7", {"word ", scen}, {24'd0, frame, data}, {24'd0, e});
        end
      end
    end
  end

  task automatic smp(input logic l);
    @(negedge clk); line = l; en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic run(input int k);
    int j;
    j = 0;
    if (jit_on != 0) begin j = (jit_idx % 3) - 1; jit_idx++; end
    lvl = ~lvl;
    repeat (k * OSR + j) smp(lvl);
  endtask

  task automatic idle(input int n);
    repeat (n) smp(lvl);
  endtask

  task automatic send_pre(input logic [2:0] kind);
    case (kind)
      K_M: begin run(3); run(3); run(1); run(1); frm_m = (frm_m + 1) % 192; end
      K_W: begin run(3); run(2); run(1); run(2); end
      default: begin run(3); run(1); run(1); run(3); frm_m = 0; end
    endcase
  endtask

  task automatic send_bits(input logic [27:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      if (i < 28 && b[i]) begin run(1); run(1); end
      else run(2);
    end
  endtask

  task automatic send_sub(input logic [2:0] kind, input logic [26:0] pay,
                          input bit badp, input bit expect_w);
    logic [27:0] bits;
    bits = {(^pay) ^ badp, pay};
    send_pre(kind);
    send_bits(bits, 28);
    if (expect_w) exp_q.push_back({frm_m[7:0], kind, bits, ^bits});
  endtask

  task automatic tail();
    run(3);
    lvl = ~lvl;
    idle(40);
  endtask

  task automatic end_checks(input string s);
    chk(exp_q.size() == 0, "R5", {"words missing ", s}, 64'(exp_q.size()), 64'd0);
    chk(lost_cnt == lost_exp, "R8", {"sync-lost pulses ", s}, 64'(lost_cnt), 64'(lost_exp));
    chk(!locked, "R11", {"locked after idle ", s}, {63'd0, locked}, 64'd0);
    chk(ovf_cnt == ovf_exp, "R10", {"overflow pulses ", s}, 64'(ovf_cnt), 64'(ovf_exp));
  endtask

  task automatic main_seq();
    rst_n = 1'b0; en = 1'b0; line = 1'b0; ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!valid && !locked && !lost && !ovf, "R1", "reset outputs",
        {60'd0, valid, locked, lost, ovf}, 64'd0);

    // normal polarity, block start, R7 frame indices 0,0,1,1,2,2
    scen = "normal";
    idle(10);
    send_sub(K_B, 27'h5A5A5A5, 1'b0, 1'b1);
    send_sub(K_W, 27'h0000000, 1'b0, 1'b1);
    chk(locked, "R11", "locked mid-burst", {63'd0, locked}, 64'd1);
    send_sub(K_M, 27'h7FFFFFF, 1'b0, 1'b1);
    send_sub(K_W, 27'h1234567, 1'b0, 1'b1);
    send_sub(K_M, 27'h0F0F0F0, 1'b0, 1'b1);
    send_sub(K_W, 27'h2AAAAAA, 1'b0, 1'b1);
    tail(); lost_exp++;
    end_checks("normal");

    // R3 inverted polarity, R2 run jitter, R6 single bit error
    scen = "R2 R3 inverted+jitter";
    lvl = 1'b1; idle(20);
    jit_on = 1;
    send_sub(K_M, 27'h3C3C3C3, 1'b0, 1'b1);
    send_sub(K_W, 27'h0000001, 1'b1, 1'b1);
    send_sub(K_M, 27'h6DB6DB6, 1'b0, 1'b1);
    send_sub(K_W, 27'h1111111, 1'b0, 1'b1);
    tail(); lost_exp++;
    end_checks("inverted");

    // R8 subframe overruns 64 UI without a preamble
    scen = "R8 timeout";
    send_sub(K_M, 27'h0ABCDEF, 1'b0, 1'b1);
    send_pre(K_W);
    send_bits(28'h0, 30);
    lost_exp++;
    send_sub(K_M, 27'h7654321, 1'b0, 1'b1);
    send_sub(K_W, 27'h0C0FFEE, 1'b0, 1'b1);
    tail(); lost_exp++;
    end_checks("timeout");

    // R8 over-long level run cuts a subframe
    scen = "R8 long run";
    send_sub(K_W, 27'h4444444, 1'b0, 1'b1);
    send_pre(K_M);
    send_bits(28'h0000155, 10);
    run(5); lost_exp++;
    send_sub(K_W, 27'h0123456, 1'b0, 1'b1);
    tail(); lost_exp++;
    end_checks("cut");

    // R9 R10 consumer stalled across a whole burst
    scen = "R9 R10 stall";
    @(posedge clk); #1 ready = 1'b0;
    send_sub(K_B, 27'h5555555, 1'b0, 1'b1);
    send_sub(K_W, 27'h2222222, 1'b0, 1'b0);
    send_sub(K_M, 27'h3333333, 1'b0, 1'b0);
    send_sub(K_W, 27'h7777777, 1'b0, 1'b0);
    tail(); lost_exp++; ovf_exp += 3;
    chk(valid, "R9", "word held while stalled", {63'd0, valid}, 64'd1);
    @(posedge clk); #1 ready = 1'b1;
    idle(10);
    end_checks("stall");
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog expired act=%0d exp=%0d", 150000, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule